// File: doc/BRIEF.md
# Single-Wire Bus Slave Slot Timing Engine

This block is the timing layer of a slave on a single-wire, open-drain serial bus. It watches a data line that has already been synchronised to the system clock and drives one pull-down enable. It measures how long the line stays low to tell a bus reset from a data slot. After a reset it answers with a presence pulse. It turns master write slots into received bits. On slots where the layer above has a bit to send, it serves those slots as read slots. Every duration is set in microseconds and scaled by a parameter that gives the number of clock cycles per microsecond.

A noise front end sits ahead of the slot logic. A falling edge counts only after a set number of consecutive low samples. After every rising edge, a hold-off window starts in which new lows are not taken as slot starts. A low that is still present when the window closes starts a slot in the normal way.

Both bit streams follow valid/ready rules, but neither can stall the wire. Received bits come out as a one-cycle `rx_valid_o` pulse with no ready signal, so the consumer must take every pulse. For transmit, `tx_ready_o` pulses for one cycle at each recognised slot start. The bit is transferred in that cycle if `tx_valid_i` is high, and that slot then becomes a read slot. The layer above must present `tx_valid_i` and `tx_bit_i` before the master's falling edge and hold them until the handshake.

Top module: `ow_slave_phy`

## Requirements
- R1: After reset, `pull_o` is low and none of `bus_reset_o`, `bus_err_o`, `rx_valid_o` or `tx_ready_o` pulses while the line stays high.
- R2: A filtered low lasting 480 µs or more gives one `bus_reset_o` pulse when the line returns high. No bit is reported for it.
- R3: After a bus reset, `pull_o` stays low for 30 µs (inside the 15–60 µs limits) and then stays high for 120 µs (inside the 60–240 µs limits) as the presence response.
- R4: In a write slot whose low time is shorter than 30 µs, one `rx_valid_o` pulse comes out with `rx_bit_o` = 1 at the rising edge.
- R5: In a write slot whose low time is from 30 µs to 120 µs, one `rx_valid_o` pulse comes out with `rx_bit_o` = 0 at the rising edge.
- R6: A low lasting more than 120 µs but less than 480 µs gives one `bus_err_o` pulse. It gives no `rx_valid_o` and no `bus_reset_o`.
- R7: `tx_ready_o` pulses for exactly one cycle at each recognised slot start. A slot whose start sees `tx_valid_i` high is a read slot and produces no `rx_valid_o`.
- R8: In a read slot with `tx_bit_i` = 0, `pull_o` is high from the cycle after the handshake until 30 µs after the slot start. With `tx_bit_i` = 1, `pull_o` stays low for the whole slot.
- R9: A low run shorter than `FILT_CYC` consecutive samples starts no slot. A run of exactly `FILT_CYC` samples does start one.
- R10: For `HOLD_US` µs after each filtered rising edge, lows start no slot. A low that is still present after the window starts a slot.
- R11: At most one of `bus_reset_o`, `bus_err_o` and `rx_valid_o` is high in any cycle, and each of them is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised sample of the bus line (1 = high) |
| pull_o | output | 1 | Open-drain pull-down enable (1 = pull line low) |
| bus_reset_o | output | 1 | One-cycle pulse: a bus reset was seen |
| bus_err_o | output | 1 | One-cycle pulse: a low that was too long for a slot and too short for a reset |
| rx_valid_o | output | 1 | One-cycle pulse: a received write bit is on `rx_bit_o` (no back-pressure) |
| rx_bit_o | output | 1 | Received bit value |
| tx_valid_i | input | 1 | Layer above has a bit to send in the next slot |
| tx_bit_i | input | 1 | Bit to send (0 = pull line low) |
| tx_ready_o | output | 1 | One-cycle pulse at each slot start; the bit is transferred if `tx_valid_i` is high |

## Verification
The hardest case to reach from the ports is the hold-off window. It needs a low that begins only a few cycles after a filtered rising edge. One such low must vanish inside the window, and another must outlast it. The bench counts clock cycles from the master's release of the line and places both kinds of low at exact offsets. It then counts `tx_ready_o` pulses and received bits to show which lows became slots. For read slots, the line is modelled as the wired-AND of master and slave. The bench samples it at the master's 13 µs read point, so the bit sent is seen on the wire itself.

// File: rtl/ow_phy_pkg.sv
package ow_phy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_PDH,
    ST_PDL
  } slot_state_e;

  localparam int RST_US  = 480;  // minimum low time of a bus reset
  localparam int ERR_US  = 120;  // longest low time still taken as a slot
  localparam int SAMP_US = 30;   // write sample point
  localparam int REL_US  = 30;   // read-zero release point
  localparam int PDH_US  = 30;   // wait before presence
  localparam int PDL_US  = 120;  // presence pulse length
endpackage

// File: rtl/ow_edge_filter.sv
module ow_edge_filter #(
  parameter int FILT_CYC    = 3,
  parameter int CLKS_PER_US = 50,
  parameter int HOLD_US     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int HOLD_C = HOLD_US * CLKS_PER_US;
  localparam int HW     = $clog2(HOLD_C + 1);
  localparam int FW     = $clog2(FILT_CYC + 1);
  localparam logic [HW-1:0] K_HOLD = HW'(HOLD_C);
  localparam logic [FW-1:0] K_FILT = FW'(FILT_CYC - 1);

  logic          line_q;
  logic          lvl_lo;
  logic [FW-1:0] lo_run;
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      lvl_lo <= 1'b0;
      lo_run <= '0;
      hold   <= '0;
      fall_o <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      line_q <= line_i;
      fall_o <= 1'b0;
      rise_o <= 1'b0;
      if (lvl_lo) begin
        if (line_q) begin
          lvl_lo <= 1'b0;
          rise_o <= 1'b1;
          hold   <= K_HOLD;
        end
      end else if (hold != '0) begin
        hold   <= hold - 1'b1;
        lo_run <= '0;
      end else if (!line_q) begin
        if (lo_run == K_FILT) begin
          lvl_lo <= 1'b1;
          fall_o <= 1'b1;
          lo_run <= '0;
        end else begin
          lo_run <= lo_run + 1'b1;
        end
      end else begin
        lo_run <= '0;
      end
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_phy_pkg::*;
#(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic rise_i,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic tx_ready_o,
  output logic pull_o,
  output logic bus_reset_o,
  output logic bus_err_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  localparam int T_RST = RST_US * CLKS_PER_US;
  localparam int CW    = $clog2(T_RST + 1);
  localparam logic [CW-1:0] K_RST  = CW'(T_RST);
  localparam logic [CW-1:0] K_ERR  = CW'(ERR_US * CLKS_PER_US);
  localparam logic [CW-1:0] K_SAMP = CW'(SAMP_US * CLKS_PER_US);
  localparam logic [CW-1:0] K_REL  = CW'(REL_US * CLKS_PER_US);
  localparam logic [CW-1:0] K_PDH  = CW'(PDH_US * CLKS_PER_US - 1);
  localparam logic [CW-1:0] K_PDL  = CW'(PDL_US * CLKS_PER_US - 1);

  slot_state_e   state;
  logic [CW-1:0] cnt;
  logic          rd_slot;
  logic          rd_zero;

  assign tx_ready_o = (state == ST_IDLE) && fall_i;
  assign pull_o     = (state == ST_PDL) ||
                      ((state == ST_LOW) && rd_zero && (cnt < K_REL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      rd_slot     <= 1'b0;
      rd_zero     <= 1'b0;
      bus_reset_o <= 1'b0;
      bus_err_o   <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_bit_o    <= 1'b0;
    end else begin
      bus_reset_o <= 1'b0;
      bus_err_o   <= 1'b0;
      rx_valid_o  <= 1'b0;
      unique case (state)
        ST_IDLE: if (fall_i) begin
          state   <= ST_LOW;
          cnt     <= '0;
          rd_slot <= tx_valid_i;
          rd_zero <= tx_valid_i && !tx_bit_i;
        end
        ST_LOW: begin
          if (cnt != K_RST) cnt <= cnt + 1'b1;
          if (rise_i) begin
            state <= ST_IDLE;
            if (cnt >= K_RST) begin
              bus_reset_o <= 1'b1;
              state       <= ST_PDH;
              cnt         <= '0;
            end else if (cnt > K_ERR) begin
              bus_err_o <= 1'b1;
            end else if (!rd_slot) begin
              rx_valid_o <= 1'b1;
              rx_bit_o   <= (cnt < K_SAMP);
            end
          end
        end
        ST_PDH: begin
          cnt <= cnt + 1'b1;
          if (cnt == K_PDH) begin
            state <= ST_PDL;
            cnt   <= '0;
          end
        end
        ST_PDL: begin
          cnt <= cnt + 1'b1;
          if (cnt == K_PDL) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy #(
  parameter int CLKS_PER_US = 50,
  parameter int FILT_CYC    = 3,
  parameter int HOLD_US     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic pull_o,
  output logic bus_reset_o,
  output logic bus_err_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic tx_ready_o
);
  logic fall;
  logic rise;

  ow_edge_filter #(
    .FILT_CYC    (FILT_CYC),
    .CLKS_PER_US (CLKS_PER_US),
    .HOLD_US     (HOLD_US)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  ow_slot_engine #(
    .CLKS_PER_US (CLKS_PER_US)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_i      (fall),
    .rise_i      (rise),
    .tx_valid_i  (tx_valid_i),
    .tx_bit_i    (tx_bit_i),
    .tx_ready_o  (tx_ready_o),
    .pull_o      (pull_o),
    .bus_reset_o (bus_reset_o),
    .bus_err_o   (bus_err_o),
    .rx_valid_o  (rx_valid_o),
    .rx_bit_o    (rx_bit_o)
  );
endmodule

// File: rtl/ow_slave_phy_chk.sv
module ow_slave_phy_chk #(
  parameter int CLKS_PER_US = 50
) (
  input logic clk,
  input logic rst_n,
  input logic pull_o,
  input logic bus_reset_o,
  input logic bus_err_o,
  input logic rx_valid_o,
  input logic tx_valid_i,
  input logic tx_bit_i,
  input logic tx_ready_o
);
  localparam int T_PDL = 120 * CLKS_PER_US;
  localparam int RW    = $clog2(T_PDL + 2);
  localparam logic [RW-1:0] K_PDL = RW'(T_PDL);

  logic [RW-1:0] pull_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pull_run <= '0;
    else if (pull_o) pull_run <= (pull_run == K_PDL) ? pull_run : pull_run + 1'b1;
    else             pull_run <= '0;
  end

  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_reset_o, bus_err_o, rx_valid_o}));
  assert_rx_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  assert_read_zero_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && tx_valid_i && !tx_bit_i) |=> pull_o);
  assert_read_one_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && tx_valid_i && tx_bit_i) |=> !pull_o);
  assert_presence_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_o |=> !pull_o);
  assert_pull_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> (pull_run < K_PDL));
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);
endmodule

bind ow_slave_phy ow_slave_phy_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pull_o      (pull_o),
  .bus_reset_o (bus_reset_o),
  .bus_err_o   (bus_err_o),
  .rx_valid_o  (rx_valid_o),
  .tx_valid_i  (tx_valid_i),
  .tx_bit_i    (tx_bit_i),
  .tx_ready_o  (tx_ready_o)
);

// File: tb/ow_slave_phy_tb.sv
module ow_slave_phy_tb;
  localparam int CPU  = 10;
  localparam int FILT = 3;
  localparam int HOLD = 2;
  localparam int NV   = 7;
  // vector table: master low time (us), tx valid, tx bit, rx pulses, rx bit, line at 13 us
  localparam int V_LOW  [NV] = '{5, 70, 25, 35, 110, 2, 2};
  localparam int V_TXV  [NV] = '{0, 0, 0, 0, 0, 1, 1};
  localparam int V_TXB  [NV] = '{0, 0, 0, 0, 0, 0, 1};
  localparam int V_RXN  [NV] = '{1, 1, 1, 1, 1, 0, 0};
  localparam int V_RXB  [NV] = '{1, 0, 1, 0, 0, 0, 0};
  localparam int V_SAMP [NV] = '{1, 0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_pull = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b0;
  logic line, pull, bus_rst, bus_err, rx_valid, rx_bit, tx_ready;
  int   n_chk = 0, n_fail = 0;
  int   c_rx = 0, c_err = 0, c_rst = 0, c_rdy = 0, c_hs = 0, cycles = 0;
  logic last_bit = 1'b0;
  logic samp;

  always #10 clk = ~clk;
  assign line = ~(m_pull | pull);

  ow_slave_phy #(.CLKS_PER_US(CPU), .FILT_CYC(FILT), .HOLD_US(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .pull_o(pull),
    .bus_reset_o(bus_rst), .bus_err_o(bus_err), .rx_valid_o(rx_valid),
    .rx_bit_o(rx_bit), .tx_valid_i(tx_valid), .tx_bit_i(tx_bit),
    .tx_ready_o(tx_ready));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rx_valid) begin c_rx <= c_rx + 1; last_bit <= rx_bit; end
    if (bus_err)  c_err <= c_err + 1;
    if (bus_rst)  c_rst <= c_rst + 1;
    if (tx_ready) c_rdy <= c_rdy + 1;
    if (tx_ready && tx_valid) c_hs <= c_hs + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master low for low_cyc cycles, slot lasts at least len_cyc; line sampled at 13 us
  task automatic slot(input int low_cyc, input int len_cyc);
    int total;
    total = (low_cyc + 10 * CPU > len_cyc) ? low_cyc + 10 * CPU : len_cyc;
    m_pull = 1'b1;
    for (int t = 0; t < total; t++) begin
      if (t == low_cyc) m_pull = 1'b0;
      if (t == 13 * CPU) samp = line;
      @(negedge clk);
    end
  endtask

  initial begin
    int rx0, rdy0, hs0, err0, rst0, d, len;
    idle(5);
    rst_n = 1'b1;
    idle(50);
    check("R1 pull idle", pull, 0);
    check("R1 no events", c_rx + c_err + c_rst + c_rdy, 0);

    // R2/R3: bus reset and presence
    rst0 = c_rst; rx0 = c_rx;
    m_pull = 1'b1; idle(500 * CPU); m_pull = 1'b0;
    d = 0;
    while (!pull && d < 100 * CPU) begin @(negedge clk); d++; end
    len = 0;
    while (pull && len < 300 * CPU) begin @(negedge clk); len++; end
    idle(20 * CPU);
    check("R2 reset pulse", c_rst - rst0, 1);
    check("R2 no bit on reset", c_rx - rx0, 0);
    check_rng("R3 presence wait", d, 15 * CPU, 60 * CPU);
    check_rng("R3 presence length", len, 60 * CPU, 240 * CPU);

    // R4 R5 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      rx0 = c_rx; hs0 = c_hs; rdy0 = c_rdy;
      tx_valid = V_TXV[i][0]; tx_bit = V_TXB[i][0];
      slot(V_LOW[i] * CPU, 80 * CPU);
      tx_valid = 1'b0;
      check((V_TXV[i] != 0) ? "R7 read slot no rx" : "R4/R5 rx count", c_rx - rx0, V_RXN[i]);
      if (V_RXN[i] != 0)
        check((V_RXB[i] != 0) ? "R4 bit one" : "R5 bit zero", int'(last_bit), V_RXB[i]);
      check("R8 line at 13us", int'(samp), V_SAMP[i]);
      check("R7 handshake", c_hs - hs0, V_TXV[i]);
      check("R7 one ready per slot", c_rdy - rdy0, 1);
    end

    // R6: too long for a slot, too short for a reset
    err0 = c_err; rx0 = c_rx; rst0 = c_rst;
    slot(200 * CPU, 0);
    check("R6 err pulse", c_err - err0, 1);
    check("R6 no rx", c_rx - rx0, 0);
    check("R6 no reset", c_rst - rst0, 0);

    // R9: filter
    rdy0 = c_rdy;
    m_pull = 1'b1; idle(FILT - 1); m_pull = 1'b0; idle(20 * CPU);
    check("R9 short glitch ignored", c_rdy - rdy0, 0);
    rx0 = c_rx;
    m_pull = 1'b1; idle(FILT); m_pull = 1'b0; idle(20 * CPU);
    check("R9 full run starts slot", c_rdy - rdy0, 1);
    check("R9 bit one", c_rx - rx0, 1);

    // R10: hold-off window
    rdy0 = c_rdy; rx0 = c_rx;
    m_pull = 1'b1; idle(5 * CPU); m_pull = 1'b0;
    idle(5); m_pull = 1'b1; idle(10); m_pull = 1'b0;
    idle(20 * CPU);
    check("R10 glitch in window ignored", c_rdy - rdy0, 1);
    check("R10 one bit", c_rx - rx0, 1);
    m_pull = 1'b1; idle(5 * CPU); m_pull = 1'b0;
    idle(5); m_pull = 1'b1; idle(10 * CPU); m_pull = 1'b0;
    idle(20 * CPU);
    check("R10 late low starts slot", c_rdy - rdy0, 3);
    check("R10 late slot bit", c_rx - rx0, 3);
    check("R10 late slot value", int'(last_bit), 1);
    check("R1 pull released at end", pull, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule